// File: doc/BRIEF.md
# Arbitrating Serial Byte Shifter

This block moves one byte across a shared two-wire serial bus whose data line is open-drain and wired-AND. It relies on an external synchronizer for two single-cycle strobes: one marks the clock line going high, the other marks it going low. The block changes its drive only after a falling-clock strobe, and samples the wire at each rising-clock strobe. A byte is eight data bits followed by a ninth acknowledge slot.

In transmit mode the block shifts out the loaded byte. It releases the line during the acknowledge slot and records the level the receiver put there. In receive mode it never drives the data bits. It collects them, then pulls the line low in the acknowledge slot when asked to acknowledge.

Whenever the block is the party that drives a bit, it compares the wire against that bit. If it released the line but sees it low, it has lost arbitration. It stops driving at once, raises a sticky lost flag, and keeps following clock pulses to the end of the byte, so its bit count stays aligned with the bus. A start or stop indication from the surrounding controller clears the flag. The block's only output toward the line is a pull-low enable.

Top module: `arb_byte_tx`

## Requirements
- R1: After reset, `sda_pull`, `busy`, `done` and `lost` are 0.
- R2: In transmit mode the data bits go out most significant first. `sda_pull` is 1 exactly when the current bit is 0. It takes the bit's value in the cycle after `go` (first bit) or after the `scl_fall` strobe that ends the previous bit, and at no other time except on a loss or a `bus_event`.
- R3: At each `scl_rise` strobe of a data bit, the wire level is sampled. When `done` is high, `rx_byte` holds the eight sampled levels, the first-sampled level in bit 7.
- R4: In transmit mode `sda_pull` is 0 during the ninth slot. `ack_bit` holds the wire level sampled at the ninth `scl_rise` (0 means acknowledged).
- R5: In receive mode `sda_pull` stays 0 for all eight data bits. In the ninth slot it equals the inverse of `ack_drive` as latched at `go` (`ack_drive` = 0 requests an acknowledge).
- R6: If the block drives a bit by releasing the line and samples 0 at `scl_rise`, then `lost` is 1 and `sda_pull` is 0 in the next cycle. `sda_pull` stays 0 for the rest of the byte.
- R7: After a loss the block keeps counting clock pulses. `done` still comes at the end of the ninth slot, and `rx_byte` holds the wire levels, including bits sent by the winner.
- R8: In receive mode, a not-acknowledge (`ack_drive` = 1) that samples 0 in the ninth slot sets `lost`.
- R9: `lost` holds until a `bus_event` pulse. `bus_event` clears it, ends any byte in progress, and releases the line without a `done`.
- R10: `done` is a one-cycle pulse in the cycle after the ninth `scl_fall` strobe, and `busy` drops in that same cycle.
- R11: A `go` pulse while `busy` is 1 is ignored and does not change the byte in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_rise | input | 1 | Strobe: serial clock went high (sample point) |
| scl_fall | input | 1 | Strobe: serial clock went low (change point) |
| sda_in | input | 1 | Synchronized level of the data wire |
| bus_event | input | 1 | Start or stop seen on the bus; clears loss and aborts |
| go | input | 1 | Begin one byte (ignored while busy) |
| rx_mode | input | 1 | 0 = transmit byte, 1 = receive byte |
| tx_byte | input | W | Byte to transmit |
| ack_drive | input | 1 | Acknowledge to give in receive mode (0 = acknowledge) |
| sda_pull | output | 1 | Pull-low enable for the data wire |
| busy | output | 1 | A byte is in progress |
| done | output | 1 | One-cycle end-of-byte pulse |
| rx_byte | output | W | Levels sampled during the data bits |
| ack_bit | output | 1 | Level sampled in the acknowledge slot |
| lost | output | 1 | Sticky arbitration-loss flag |

## Verification
Every result is registered once. `sda_pull` settles one cycle after `go` or after an `scl_fall` strobe. `lost` and a forced release settle one cycle after the `scl_rise` strobe that sees the mismatch. `done`, `rx_byte` and `ack_bit` are valid one cycle after the ninth `scl_fall` strobe, and `done` is gone one cycle later. The bench drives each strobe for exactly one cycle and reads the outputs on the falling clock edge just after the rising edge that registers them. Expected values come from a wired-AND model of the wire that is evaluated bit by bit.

// File: rtl/arb_tx_pkg.sv
package arb_tx_pkg;

   typedef enum logic {
      MODE_TX = 1'b0,
      MODE_RX = 1'b1
   } xfer_mode_e;

   function automatic int cnt_bits(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/arb_tx_bitcnt.sv
module arb_tx_bitcnt
   import arb_tx_pkg::*;
#(
   parameter int W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic in_ack,
   output logic pre_ack
);
   localparam int CW = cnt_bits(W);
   localparam logic [CW-1:0] ACK_SLOT = CW'(W);
   localparam logic [CW-1:0] LAST_DATA = CW'(W - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (step)
         cnt_q <= (cnt_q == ACK_SLOT) ? '0 : cnt_q + 1'b1;
   end

   assign in_ack  = (cnt_q == ACK_SLOT);
   assign pre_ack = (cnt_q == LAST_DATA);
endmodule

// File: rtl/arb_tx_shift.sv
module arb_tx_shift #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] tx_word,
   input  logic         advance,
   input  logic         sample,
   input  logic         sda_in,
   output logic         first_bit,
   output logic         next_bit,
   output logic [W-1:0] rx_word
);
   logic [W-1:0] tx_q;
   logic [W-1:0] rx_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign first_bit = tx_word[W-1];
         assign next_bit  = tx_q[W-2];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_q <= '0;
               rx_q <= '0;
            end else if (load) begin
               tx_q <= tx_word;
               rx_q <= '0;
            end else begin
               if (advance) tx_q <= {tx_q[W-2:0], 1'b0};
               if (sample)  rx_q <= {rx_q[W-2:0], sda_in};
            end
         end
      end else begin : g_lsb
         assign first_bit = tx_word[0];
         assign next_bit  = tx_q[1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_q <= '0;
               rx_q <= '0;
            end else if (load) begin
               tx_q <= tx_word;
               rx_q <= '0;
            end else begin
               if (advance) tx_q <= {1'b0, tx_q[W-1:1]};
               if (sample)  rx_q <= {sda_in, rx_q[W-1:1]};
            end
         end
      end
   endgenerate

   assign rx_word = rx_q;
endmodule

// File: rtl/arb_tx_arbmon.sv
module arb_tx_arbmon (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic sample,
   input  logic role_drv,
   input  logic pull,
   input  logic sda_in,
   output logic mismatch,
   output logic lost
);
   logic lost_q;

   // released while driving, yet the wire reads low
   assign mismatch = sample & role_drv & ~pull & ~sda_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lost_q <= 1'b0;
      else if (clear)
         lost_q <= 1'b0;
      else if (mismatch)
         lost_q <= 1'b1;
   end

   assign lost = lost_q;
endmodule

// File: rtl/arb_byte_tx.sv
module arb_byte_tx
   import arb_tx_pkg::*;
#(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         scl_rise,
   input  logic         scl_fall,
   input  logic         sda_in,
   input  logic         bus_event,
   input  logic         go,
   input  logic         rx_mode,
   input  logic [W-1:0] tx_byte,
   input  logic         ack_drive,
   output logic         sda_pull,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] rx_byte,
   output logic         ack_bit,
   output logic         lost
);
   generate
      if (W < 2) begin : g_bad_width
         $error("arb_byte_tx: W must be at least 2");
      end
   endgenerate

   xfer_mode_e   mode_q;
   logic         busy_q, ack_q, pull_q, done_q, ackbit_q;
   logic [W-1:0] rxb_q;

   logic         in_ack, pre_ack;
   logic         first_bit, next_bit;
   logic [W-1:0] rx_word;
   logic         mismatch, lost_w, lost_now;
   logic         start, adv, smp, role_drv;

   assign start    = go & ~busy_q & ~bus_event;
   assign adv      = busy_q & scl_fall & ~in_ack;
   assign smp      = busy_q & scl_rise & ~in_ack;
   assign role_drv = in_ack ? (mode_q == MODE_RX) : (mode_q == MODE_TX);
   assign lost_now = lost_w | mismatch;

   arb_tx_bitcnt #(.W(W)) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start | bus_event),
      .step   (busy_q & scl_fall),
      .in_ack (in_ack),
      .pre_ack(pre_ack)
   );

   arb_tx_shift #(.W(W), .MSB_FIRST(MSB_FIRST)) shf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .tx_word  (tx_byte),
      .advance  (adv),
      .sample   (smp),
      .sda_in   (sda_in),
      .first_bit(first_bit),
      .next_bit (next_bit),
      .rx_word  (rx_word)
   );

   arb_tx_arbmon arb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (bus_event),
      .sample  (busy_q & scl_rise & ~bus_event),
      .role_drv(role_drv),
      .pull    (pull_q),
      .sda_in  (sda_in),
      .mismatch(mismatch),
      .lost    (lost_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_TX;
         busy_q   <= 1'b0;
         ack_q    <= 1'b1;
         pull_q   <= 1'b0;
         done_q   <= 1'b0;
         ackbit_q <= 1'b1;
         rxb_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (bus_event) begin
            busy_q <= 1'b0;
            pull_q <= 1'b0;
         end else if (start) begin
            busy_q <= 1'b1;
            mode_q <= xfer_mode_e'(rx_mode);
            ack_q  <= ack_drive;
            pull_q <= ~rx_mode & ~first_bit & ~lost_w;
         end else if (busy_q) begin
            if (mismatch)
               pull_q <= 1'b0;
            if (scl_rise && in_ack)
               ackbit_q <= sda_in;
            if (scl_fall) begin
               if (in_ack) begin
                  busy_q <= 1'b0;
                  pull_q <= 1'b0;
                  done_q <= 1'b1;
                  rxb_q  <= rx_word;
               end else if (pre_ack) begin
                  pull_q <= (mode_q == MODE_RX) & ~ack_q & ~lost_now;
               end else begin
                  pull_q <= (mode_q == MODE_TX) & ~next_bit & ~lost_now;
               end
            end
         end
      end
   end

   assign sda_pull = pull_q;
   assign busy     = busy_q;
   assign done     = done_q;
   assign rx_byte  = rxb_q;
   assign ack_bit  = ackbit_q;
   assign lost     = lost_w;
endmodule

// File: rtl/arb_byte_tx_chk.sv
module arb_byte_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_rise,
   input logic scl_fall,
   input logic go,
   input logic bus_event,
   input logic sda_in,
   input logic sda_pull,
   input logic busy,
   input logic done,
   input logic lost,
   input logic in_ack,
   input logic role_drv,
   input logic mode_rx
);
   // R2: drive moves only after go, a falling strobe, a sample or a bus event
   p_pull_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(go || scl_fall || scl_rise || bus_event) |=> $stable(sda_pull));

   // R2: a sample point never starts pulling the line
   p_no_pull_on_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_rise && !go && !scl_fall) |=> !$rose(sda_pull));

   // R4: the transmitter leaves the ninth slot to the receiver
   p_tx_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mode_rx && in_ack) |-> !sda_pull);

   // R5: the receiver stays off the line for the data bits
   p_rx_data_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_rx && !in_ack) |-> !sda_pull);

   // R6: a loss means the line is released
   p_lost_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lost |-> !sda_pull);

   // R6, R8: released bit read back low sets the flag
   p_mismatch_sets_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && scl_rise && !bus_event && role_drv && !sda_pull && !sda_in) |=> lost);

   // R9: flag held until a bus event
   p_lost_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lost && !bus_event) |=> lost);

   // R10: done is one cycle wide and ends the byte
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !sda_pull) ##1 !done);
endmodule

bind arb_byte_tx arb_byte_tx_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_rise (scl_rise),
   .scl_fall (scl_fall),
   .go       (go),
   .bus_event(bus_event),
   .sda_in   (sda_in),
   .sda_pull (sda_pull),
   .busy     (busy),
   .done     (done),
   .lost     (lost),
   .in_ack   (in_ack),
   .role_drv (role_drv),
   .mode_rx  (mode_q == arb_tx_pkg::MODE_RX)
);

// File: tb/arb_byte_tx_tb_top.sv
module arb_byte_tx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_rise = 1'b0, scl_fall = 1'b0, bus_event = 1'b0, go = 1'b0;
   logic       rx_mode = 1'b0, ack_drive = 1'b1, other_lvl = 1'b1;
   logic [7:0] tx_byte = 8'h00;
   logic       sda_pull, busy, done, ack_bit, lost, sda_in;
   logic [7:0] rx_byte;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   // wired-AND bus: another device plus this one
   assign sda_in = other_lvl & ~sda_pull;

   arb_byte_tx #(.W(8), .MSB_FIRST(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_in(sda_in), .bus_event(bus_event), .go(go), .rx_mode(rx_mode),
      .tx_byte(tx_byte), .ack_drive(ack_drive), .sda_pull(sda_pull),
      .busy(busy), .done(done), .rx_byte(rx_byte), .ack_bit(ack_bit), .lost(lost)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse_bus_event();
      bus_event = 1'b1;
      @(negedge clk);
      bus_event = 1'b0;
   endtask

   // one full byte; oth[8:1] are the other device's data levels, oth[0] its ack level
   task automatic run_byte(input logic [7:0] txb, input logic rxm, input logic ackd,
                           input logic [8:0] oth, input bit inj);
      logic       lostx;
      logic       pe, wire_l, mine;
      logic [7:0] rxexp;
      logic       ackexp;
      lostx = 1'b0;
      rxexp = 8'h00;
      ackexp = 1'b1;
      pulse_bus_event();
      tx_byte = txb; rx_mode = rxm; ack_drive = ackd; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      for (int i = 0; i < 9; i++) begin
         if (inj && i == 3) begin
            tx_byte = ~txb; rx_mode = ~rxm; ack_drive = ~ackd; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
         end
         other_lvl = oth[8-i];
         if (i < 8) begin
            mine = txb[7-i];
            pe = (!rxm) && !lostx && !mine;
            wire_l = oth[8-i] & !pe;
            if (!rxm && !lostx && mine && !oth[8-i]) lostx = 1'b1;
            rxexp[7-i] = wire_l;
         end else begin
            pe = rxm && !ackd;
            wire_l = oth[0] & !pe;
            if (rxm && ackd && !oth[0]) lostx = 1'b1;
            ackexp = wire_l;
         end
         @(negedge clk);
         if (i == 8) chk({7'd0, sda_pull}, {7'd0, pe}, rxm ? "R8 ack drive" : "R4 ack release");
         else if (rxm) chk({7'd0, sda_pull}, {7'd0, pe}, "R5 rx data quiet");
         else chk({7'd0, sda_pull}, {7'd0, pe}, lostx ? "R6 drive after loss" : "R2 data drive");
         scl_rise = 1'b1;
         @(negedge clk);
         scl_rise = 1'b0;
         @(negedge clk);
         scl_fall = 1'b1;
         @(negedge clk);
         scl_fall = 1'b0;
         if (i < 8) chk({7'd0, done}, 8'd0, "R10 no early done");
      end
      chk({7'd0, done}, 8'd1, "R10 done pulse");
      chk({7'd0, busy}, 8'd0, "R10 busy drop");
      chk(rx_byte, rxexp, lostx ? "R7 rx after loss" : "R3 rx byte");
      chk({7'd0, ack_bit}, {7'd0, ackexp}, "R4 ack bit");
      chk({7'd0, lost}, {7'd0, lostx}, rxm ? "R8 lost flag" : "R6 lost flag");
      if (inj) chk(rx_byte, rxexp, "R11 go ignored while busy");
      other_lvl = 1'b1;
      @(negedge clk);
      chk({7'd0, done}, 8'd0, "R10 done one cycle");
      chk({7'd0, lost}, {7'd0, lostx}, "R9 lost held");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({5'd0, sda_pull, busy, done}, 8'd0, "R1 reset outputs");
      chk({7'd0, lost}, 8'd0, "R1 reset lost");
      rst_n = 1'b1;
      @(negedge clk);
      chk({5'd0, sda_pull, busy, lost}, 8'd0, "R1 after reset release");

      // every byte value, no competitor, ack given or not
      for (int v = 0; v < 256; v++)
         run_byte(8'(v), 1'b0, 1'b1, {8'hFF, v[0]}, 1'b0);

      // competitor sweep against a few transmitted bytes
      for (int t = 0; t < 4; t++) begin
         logic [7:0] txv;
         txv = (t == 0) ? 8'hA5 : (t == 1) ? 8'h3C : (t == 2) ? 8'hFF : 8'h00;
         for (int o = 0; o < 256; o++)
            run_byte(txv, 1'b0, 1'b1, {8'(o), 1'b0}, 1'b0);
      end

      // receive mode: all data patterns, ack and not-ack against both ack levels
      for (int o = 0; o < 256; o++)
         for (int a = 0; a < 4; a++)
            run_byte(8'h00, 1'b1, a[0], {8'(o), a[1]}, 1'b0);

      // go while busy
      run_byte(8'h96, 1'b0, 1'b1, 9'h1FF, 1'b1);
      run_byte(8'h00, 1'b1, 1'b0, 9'h0B5, 1'b1);

      // loss then bus event clears; abort mid-byte gives no done
      run_byte(8'hFF, 1'b0, 1'b1, 9'h0FE, 1'b0);
      repeat (5) @(negedge clk);
      chk({7'd0, lost}, 8'd1, "R9 lost held while idle");
      pulse_bus_event();
      chk({7'd0, lost}, 8'd0, "R9 lost cleared");
      tx_byte = 8'h00; rx_mode = 1'b0; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk({7'd0, sda_pull}, 8'd1, "R2 first bit driven");
      pulse_bus_event();
      chk({6'd0, busy, sda_pull}, 8'd0, "R9 abort releases");
      for (int k = 0; k < 9; k++) begin
         scl_rise = 1'b1; @(negedge clk); scl_rise = 1'b0;
         scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
         chk({7'd0, done}, 8'd0, "R9 no done after abort");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule